// File: doc/BRIEF.md
# Two-Wire Slave Byte Memory with Upper-Half Write Lock

This block is a byte-wide register memory that answers as a slave on a two-wire serial bus. The bus clock and data lines are sampled by a fast system clock. The block never drives the clock line. On the data line it only produces a pull-low enable, and an external pull-up provides the high level. A transfer opens with a start condition. A device byte follows, carrying a fixed 4-bit type code, three bank bits and a direction bit. For a write, a word-address byte comes next and then any number of data bytes. For a read, data bytes flow out from the internal address counter.

The internal address is the three bank bits placed above a word address of `WORD_BITS` bits. It advances by one after every data byte, in either direction, and wraps over the whole array. A lock input, while high, suppresses writes to every location whose address top bit is 1, which is the upper half of the array. Such writes are still acknowledged. A start condition at any moment abandons the current transfer and expects a fresh device byte. A stop condition returns the block to idle.

The controller is a single enumerated state machine:
- `ST_IDLE`: after reset or a stop.
- `ST_DEV`: receiving the device byte.
- `ST_DEV_ACK`: acknowledging the device byte.
- `ST_WADDR`: receiving the word address.
- `ST_WADDR_ACK`: acknowledging the word address.
- `ST_WDATA`: receiving write data.
- `ST_WDATA_ACK`: acknowledging write data.
- `ST_RDATA`: shifting out read data.
- `ST_RACK`: sampling the master's acknowledge.
- `ST_WAIT`: ignoring the bus until the next start or stop.

Transitions:
- A start moves every state to `ST_DEV`. A stop moves every state to `ST_IDLE`.
- `ST_DEV` goes to `ST_DEV_ACK` on a matching type code, or to `ST_WAIT` otherwise.
- `ST_DEV_ACK` goes to `ST_RDATA` for a read, or to `ST_WADDR` for a write.
- `ST_WADDR` goes to `ST_WADDR_ACK`, and `ST_WADDR_ACK` goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RACK`. `ST_RACK` returns to `ST_RDATA` on an acknowledge, or goes to `ST_WAIT` on a not-acknowledge.

Top module: `i2c_wp_mem`

## Requirements
- R1: A start condition (SDA falling while SCL is high) followed by a device byte whose upper nibble is 1010 is acknowledged: SDA is pulled low during the ninth clock. Bits 3..1 of that byte are the bank bits, and bit 0 is 1 for read and 0 for write.
- R2: A device byte whose upper nibble is not 1010 gets no acknowledge. The bytes that follow it until the next start or stop are ignored and leave the memory unchanged.
- R3: Bytes travel most significant bit first. A write stores each data byte at address {bank, word} and acknowledges it. The word is the low `WORD_BITS` bits of the word-address byte.
- R4: The address advances by one after each data byte and wraps from the last location of the array to location 0.
- R5: In a read, data comes out MSB first from the addressed location. SDA changes only while SCL is low, so it is stable for the whole high phase of each clock.
- R6: A not-acknowledge from the master after a read byte ends the output. SDA stays released for all following clocks until a start or stop.
- R7: With the lock input high, writes to locations whose address top bit is 1 are suppressed but still acknowledged. Lower-half writes proceed, and this holds also when auto-increment crosses from the lower into the upper half.
- R8: With the lock input low, writes to the upper half proceed.
- R9: Reads of every location proceed regardless of the lock input.
- R10: A start inside a data byte abandons the transfer: the partial byte is not written, and a new device byte is accepted and acknowledged.
- R11: After reset and after a stop condition (SDA rising while SCL is high), SDA is released.
- R12: A read that is not preceded by a word-address byte starts at the current counter value, with its bank field replaced by the bank bits of the new device byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| wp_i | input | 1 | Lock input; high protects the upper half of the array |
| sda_oe_o | output | 1 | Pull-low enable for the data line (1 = drive low) |

## Verification
The bench builds the block with `WORD_BITS` = 4 and two synchronizer stages, which gives a 128-byte array of eight banks with sixteen words each. At that size, one burst writes and reads back every location, so auto-increment across every bank boundary and the wrap from 127 to 0 are both observed. Every bank is also written with the lock input both high and low. All fifteen non-matching type codes are swept against the device-byte decoder.

// File: rtl/i2c_wp_pkg.sv
package i2c_wp_pkg;

    // Number of bank bits carried in the device byte.
    localparam int BANK_BITS = 3;

    // Fixed device type code in the upper nibble of the device byte.
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Bits per byte on the bus.
    localparam int BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } state_t;

endpackage

// File: rtl/i2c_wp_cond.sv
module i2c_wp_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // Idle bus is high on both lines, so the synchronizers reset to 1.
    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end
    endgenerate

    // One more stage of history for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    assign scl_lvl  = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl  = sda_pipe[SYNC_STAGES-1];
    assign scl_rise = ~scl_q & scl_lvl;
    assign scl_fall = scl_q & ~scl_lvl;
    // Data edges while the clock stays high mark bus conditions.
    assign start_p  = scl_q & scl_lvl & sda_q & ~sda_lvl;
    assign stop_p   = scl_q & scl_lvl & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_wp_array.sv
module i2c_wp_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/i2c_wp_ctrl.sv
module i2c_wp_ctrl
    import i2c_wp_pkg::*;
#(
    parameter int WORD_BITS = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wp_i,
    input  logic                             sda_lvl,
    input  logic                             scl_rise,
    input  logic                             scl_fall,
    input  logic                             start_p,
    input  logic                             stop_p,
    input  logic [BYTE_BITS-1:0]             mem_rdata,
    output logic                             mem_we,
    output logic [BANK_BITS+WORD_BITS-1:0]   mem_addr,
    output logic [BYTE_BITS-1:0]             mem_wdata,
    output logic                             sda_oe
);

    localparam int            AW       = BANK_BITS + WORD_BITS;
    localparam int            CNT_W    = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [AW-1:0] ADDR_ONE = AW'(1);

    state_t               state;
    state_t               state_d;
    logic [CNT_W-1:0]     bitcnt;
    logic [BYTE_BITS-1:0] shreg;
    logic [BYTE_BITS-1:0] txreg;
    logic [AW-1:0]        addr;
    logic                 ninth;
    logic                 rw_q;
    logic                 mack_q;
    logic                 byte_in_done;
    logic                 dev_match;
    logic                 locked;

    assign byte_in_done = scl_fall && (bitcnt == CNT_FULL);
    assign dev_match    = (shreg[7:4] == DEV_TYPE);
    assign locked       = wp_i && addr[AW-1];

    // Next-state logic.
    always_comb begin
        state_d = state;
        if (start_p) begin
            state_d = ST_DEV;
        end else if (stop_p) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_d = ST_IDLE;
                ST_WAIT:      state_d = ST_WAIT;
                ST_DEV: begin
                    if (byte_in_done) begin
                        state_d = dev_match ? ST_DEV_ACK : ST_WAIT;
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall && ninth) begin
                        state_d = rw_q ? ST_RDATA : ST_WADDR;
                    end
                end
                ST_WADDR: begin
                    if (byte_in_done) state_d = ST_WADDR_ACK;
                end
                ST_WADDR_ACK: begin
                    if (scl_fall && ninth) state_d = ST_WDATA;
                end
                ST_WDATA: begin
                    if (byte_in_done) state_d = ST_WDATA_ACK;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall && ninth) state_d = ST_WDATA;
                end
                ST_RDATA: begin
                    if (scl_fall && (bitcnt == CNT_LAST)) state_d = ST_RACK;
                end
                ST_RACK: begin
                    if (scl_fall && ninth) begin
                        state_d = mack_q ? ST_RDATA : ST_WAIT;
                    end
                end
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Shifters, bit counter and address counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            txreg  <= '1;
            addr   <= '0;
            ninth  <= 1'b0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
        end else if (start_p) begin
            bitcnt <= '0;
            ninth  <= 1'b0;
        end else begin
            if (scl_rise) begin
                unique case (state)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (bitcnt != CNT_FULL) begin
                            shreg  <= {shreg[BYTE_BITS-2:0], sda_lvl};
                            bitcnt <= bitcnt + CNT_ONE;
                        end
                    end
                    ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                        ninth <= 1'b1;
                    end
                    ST_RACK: begin
                        ninth  <= 1'b1;
                        mack_q <= ~sda_lvl;
                    end
                    default: begin
                    end
                endcase
            end
            if (scl_fall) begin
                unique case (state)
                    ST_DEV: begin
                        if (bitcnt == CNT_FULL) begin
                            bitcnt <= '0;
                            if (dev_match) begin
                                rw_q <= shreg[0];
                                addr[AW-1 -: BANK_BITS] <= shreg[BANK_BITS:1];
                            end
                        end
                    end
                    ST_WADDR: begin
                        if (bitcnt == CNT_FULL) begin
                            bitcnt <= '0;
                            addr[WORD_BITS-1:0] <= shreg[WORD_BITS-1:0];
                        end
                    end
                    ST_WDATA: begin
                        if (bitcnt == CNT_FULL) begin
                            bitcnt <= '0;
                            addr   <= addr + ADDR_ONE;
                        end
                    end
                    ST_DEV_ACK: begin
                        if (ninth) begin
                            ninth  <= 1'b0;
                            bitcnt <= '0;
                            if (rw_q) begin
                                txreg <= mem_rdata;
                                addr  <= addr + ADDR_ONE;
                            end
                        end
                    end
                    ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (ninth) begin
                            ninth  <= 1'b0;
                            bitcnt <= '0;
                        end
                    end
                    ST_RDATA: begin
                        txreg <= {txreg[BYTE_BITS-2:0], 1'b1};
                        if (bitcnt == CNT_LAST) begin
                            bitcnt <= '0;
                        end else begin
                            bitcnt <= bitcnt + CNT_ONE;
                        end
                    end
                    ST_RACK: begin
                        if (ninth) begin
                            ninth <= 1'b0;
                            if (mack_q) begin
                                txreg <= mem_rdata;
                                addr  <= addr + ADDR_ONE;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // Memory write port: a complete data byte, outside the locked half.
    assign mem_we    = (state == ST_WDATA) && byte_in_done && !locked;
    assign mem_addr  = addr;
    assign mem_wdata = shreg;

    // Output process: pull-low enable from the registered state.
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                               sda_oe = ~txreg[BYTE_BITS-1];
            default:                                sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_wp_mem.sv
module i2c_wp_mem
    import i2c_wp_pkg::*;
#(
    parameter int WORD_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);

    localparam int AW = BANK_BITS + WORD_BITS;

    logic                 scl_lvl;
    logic                 sda_lvl;
    logic                 scl_rise;
    logic                 scl_fall;
    logic                 start_p;
    logic                 stop_p;
    logic                 mem_we;
    logic [AW-1:0]        mem_addr;
    logic [BYTE_BITS-1:0] mem_wdata;
    logic [BYTE_BITS-1:0] mem_rdata;

    i2c_wp_cond #(
        .SYNC_STAGES (SYNC_STAGES)
    ) cond_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    i2c_wp_ctrl #(
        .WORD_BITS (WORD_BITS)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wp_i      (wp_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sda_oe    (sda_oe_o)
    );

    i2c_wp_array #(
        .AW (AW),
        .DW (BYTE_BITS)
    ) array_i (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/i2c_wp_mem_chk.sv
module i2c_wp_mem_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wp_i,
    input logic          sda_oe_o,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          start_p,
    input logic          stop_p,
    input logic          scl_fall,
    input logic          scl_lvl
);

    AST_WE_AT_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> scl_fall); // R3

    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !(wp_i && mem_addr[AW-1])); // R7

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) (!$stable(sda_oe_o) && !$past(start_p) && !$past(stop_p)) |-> !scl_lvl); // R5

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) start_p |=> !sda_oe_o); // R10

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) stop_p |=> !sda_oe_o); // R11

endmodule

bind i2c_wp_mem i2c_wp_mem_chk #(
    .AW (AW)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_i     (wp_i),
    .sda_oe_o (sda_oe_o),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .scl_fall (scl_fall),
    .scl_lvl  (scl_lvl)
);

// File: tb/i2c_wp_mem_tb_top.sv
`timescale 1ns/1ps
module i2c_wp_mem_tb_top;

    localparam int WB    = 4;
    localparam int AWB   = 3 + WB;
    localparam int DEPTH = 1 << AWB;
    localparam int QCYC  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int checks = 0;
    int failures = 0;

    logic [7:0] exp_mem [DEPTH];

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_wp_mem #(
        .WORD_BITS   (WB),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (QCYC) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s, output logic st);
        sda_m = b;
        qw();
        scl_m = 1'b1;
        qw();
        s = sda_bus;
        qw();
        st = (sda_bus == s);
        scl_m = 1'b0;
        qw();
    endtask

    task automatic bus_start();
        scl_m = 1'b0; qw();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic s, st;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s, st);
        clk_bit(1'b1, s, st);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d, output logic stable);
        logic s, st;
        stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s, st);
            d[i] = s;
            stable = stable & st;
        end
        clk_bit(~mack, s, st);
    endtask

    function automatic logic [7:0] dev(input int bank, input logic rd);
        return {4'b1010, 3'(bank), rd};
    endfunction

    // Point the counter at {bank, word} with a write header, then read one byte.
    task automatic rd_at(input int bank, input int word, output logic [7:0] d);
        logic ack, st;
        bus_start();
        wr_byte(dev(bank, 1'b0), ack);
        chk(ack, "R1 device ack", ack, 1);
        wr_byte(8'(word), ack);
        chk(ack, "R3 word ack", ack, 1);
        bus_start();
        wr_byte(dev(bank, 1'b1), ack);
        chk(ack, "R1 read device ack", ack, 1);
        rd_byte(1'b0, d, st);
        chk(st, "R5 stable while SCL high", st, 1);
        bus_stop();
    endtask

    task automatic wr_at(input int bank, input int word, input logic [7:0] d, input string req);
        logic ack;
        bus_start();
        wr_byte(dev(bank, 1'b0), ack);
        chk(ack, "R1 device ack", ack, 1);
        wr_byte(8'(word), ack);
        chk(ack, "R3 word ack", ack, 1);
        wr_byte(d, ack);
        chk(ack, req, ack, 1);
        bus_stop();
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic       ack, s, st;
        logic [7:0] d;
        int         a;

        repeat (10) @(negedge clk);
        chk(sda_oe == 1'b0, "R11 released in reset", sda_oe, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(sda_oe == 1'b0, "R11 released after reset", sda_oe, 0);

        // R3 R4: fill the whole array in one burst from address 0.
        bus_start();
        wr_byte(dev(0, 1'b0), ack);
        chk(ack, "R1 device ack", ack, 1);
        wr_byte(8'h00, ack);
        chk(ack, "R3 word ack", ack, 1);
        for (int i = 0; i < DEPTH; i++) begin
            d = 8'((i * 37 + 11) & 255);
            wr_byte(d, ack);
            chk(ack, "R3 data ack", ack, 1);
            exp_mem[i] = d;
        end
        bus_stop();
        repeat (8) @(negedge clk);
        chk(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);

        // R4: wrap from the last location to location 0.
        bus_start();
        wr_byte(dev(7, 1'b0), ack);
        chk(ack, "R1 device ack", ack, 1);
        wr_byte(8'(DEPTH / 8 - 1), ack);
        chk(ack, "R4 word ack", ack, 1);
        wr_byte(8'hA5, ack);
        chk(ack, "R4 data ack", ack, 1);
        wr_byte(8'h5A, ack);
        chk(ack, "R4 wrap data ack", ack, 1);
        bus_stop();
        exp_mem[DEPTH-1] = 8'hA5;
        exp_mem[0] = 8'h5A;

        // R3 R4 R5: read every location in one burst, then R6.
        bus_start();
        wr_byte(dev(0, 1'b0), ack);
        chk(ack, "R1 device ack", ack, 1);
        wr_byte(8'h00, ack);
        chk(ack, "R3 word ack", ack, 1);
        bus_start();
        wr_byte(dev(0, 1'b1), ack);
        chk(ack, "R1 read device ack", ack, 1);
        for (int i = 0; i < DEPTH; i++) begin
            rd_byte(i != DEPTH - 1, d, st);
            chk(d == exp_mem[i], "R4 R5 burst read data", d, exp_mem[i]);
            chk(st, "R5 stable while SCL high", st, 1);
        end
        for (int k = 0; k < 3; k++) begin
            clk_bit(1'b1, s, st);
            chk(s == 1'b1, "R6 released after nack", s, 1);
        end
        bus_stop();

        // R7 R9: lock high, one write to every bank.
        wp = 1'b1;
        for (int b = 0; b < 8; b++) begin
            wr_at(b, 3, 8'hC0 | 8'(b), "R7 ack under lock");
            if (b < 4) exp_mem[b * 16 + 3] = 8'hC0 | 8'(b);
        end
        for (int b = 0; b < 8; b++) begin
            a = b * 16 + 3;
            rd_at(b, 3, d);
            chk(d == exp_mem[a], "R7 R9 lock sweep readback", d, exp_mem[a]);
        end

        // R7: a burst crossing from the lower into the upper half.
        bus_start();
        wr_byte(dev(3, 1'b0), ack);
        chk(ack, "R1 device ack", ack, 1);
        wr_byte(8'h0F, ack);
        chk(ack, "R7 word ack", ack, 1);
        wr_byte(8'h11, ack);
        chk(ack, "R7 lower data ack", ack, 1);
        wr_byte(8'h22, ack);
        chk(ack, "R7 upper data ack", ack, 1);
        bus_stop();
        exp_mem[63] = 8'h11;
        rd_at(3, 15, d);
        chk(d == exp_mem[63], "R7 lower half written", d, exp_mem[63]);
        rd_at(4, 0, d);
        chk(d == exp_mem[64], "R7 upper half kept", d, exp_mem[64]);

        // R8: lock low, upper-half writes proceed.
        wp = 1'b0;
        for (int b = 4; b < 8; b++) begin
            wr_at(b, 9, 8'h30 | 8'(b), "R8 data ack");
            exp_mem[b * 16 + 9] = 8'h30 | 8'(b);
        end
        for (int b = 4; b < 8; b++) begin
            a = b * 16 + 9;
            rd_at(b, 9, d);
            chk(d == exp_mem[a], "R8 upper write unlocked", d, exp_mem[a]);
        end

        // R2: every other device type is ignored.
        for (int t = 0; t < 16; t++) begin
            if (t != 10) begin
                bus_start();
                wr_byte({4'(t), 3'b000, 1'b0}, ack);
                chk(!ack, "R2 no ack for other type", ack, 0);
                wr_byte(8'h00, ack);
                chk(!ack, "R2 following byte ignored", ack, 0);
                wr_byte(8'hEE, ack);
                bus_stop();
            end
        end
        rd_at(0, 0, d);
        chk(d == exp_mem[0], "R2 memory unchanged", d, exp_mem[0]);

        // R10: start inside a data byte.
        bus_start();
        wr_byte(dev(1, 1'b0), ack);
        chk(ack, "R1 device ack", ack, 1);
        wr_byte(8'h05, ack);
        chk(ack, "R10 word ack", ack, 1);
        for (int k = 0; k < 4; k++) clk_bit(1'b0, s, st);
        bus_start();
        wr_byte(dev(1, 1'b0), ack);
        chk(ack, "R10 new device byte acked", ack, 1);
        wr_byte(8'h06, ack);
        chk(ack, "R10 word ack", ack, 1);
        wr_byte(8'h77, ack);
        chk(ack, "R10 data ack", ack, 1);
        bus_stop();
        exp_mem[22] = 8'h77;
        rd_at(1, 5, d);
        chk(d == exp_mem[21], "R10 partial byte not written", d, exp_mem[21]);
        rd_at(1, 6, d);
        chk(d == 8'h77, "R10 later write stored", d, 8'h77);

        // R12: current-address reads.
        wr_at(2, 7, 8'h99, "R12 data ack");
        exp_mem[39] = 8'h99;
        bus_start();
        wr_byte(dev(2, 1'b1), ack);
        chk(ack, "R1 read device ack", ack, 1);
        rd_byte(1'b0, d, st);
        bus_stop();
        chk(d == exp_mem[40], "R12 current address read", d, exp_mem[40]);
        bus_start();
        wr_byte(dev(5, 1'b1), ack);
        chk(ack, "R1 read device ack", ack, 1);
        rd_byte(1'b0, d, st);
        bus_stop();
        chk(d == exp_mem[89], "R12 bank replaced", d, exp_mem[89]);
        repeat (8) @(negedge clk);
        chk(sda_oe == 1'b0, "R11 released at end", sda_oe, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule